// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small processor that runs one instruction per clock. Every instruction is a fixed 32-bit word. The core fetches the word at the program counter, decodes it, reads up to two source registers, computes a sum, optionally touches data memory, writes back at most one register and selects the next program counter, all within one cycle. It executes six operations: register add, add-immediate, load word, store word, branch-if-equal and absolute jump. Any other encoding leaves the architectural state unchanged apart from advancing the PC.

Instruction memory and data memory are word-indexed arrays inside the core. A loader port fills instruction memory, normally while reset is held. A debug port reads any register and any data word combinationally. The PC is visible on its own output.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the PC becomes 0 and all 32 registers become 0.
- R2: Opcode 0 (bits 31:26) with function code 32 (bits 5:0) writes rd (bits 15:11) with rs (bits 25:21) plus rt (bits 20:16), modulo 2^32, and advances the PC by 4.
- R3: Opcode 8 writes rt with rs plus the sign-extended 16-bit immediate (bits 15:0).
- R4: Opcode 35 writes rt with the data word at byte address rs plus the sign-extended immediate. The word index is address bits [DA_W+1:2].
- R5: Opcode 43 stores rt into the data word at byte address rs plus the sign-extended immediate, and writes no register.
- R6: Opcode 4 sets the next PC to PC+4+(sign-extended immediate × 4) when rs equals rt, and to PC+4 otherwise. Backward offsets are allowed.
- R7: Opcode 2 sets the next PC to PC bits 31:28, followed by the 26-bit target (bits 25:0), followed by two zero bits.
- R8: Register 0 always reads as zero. Any write that names it is discarded.
- R9: Any other opcode, and opcode 0 with a function code other than 32, changes no register and no data word, and advances the PC by 4.
- R10: When `load_we` is high at a rising edge, instruction word `load_addr` takes `load_data`. The PC indexes instruction memory by bits [IA_W+1:2].
- R11: `dbg_reg_data` shows register `dbg_reg_addr`, and `dbg_mem_data` shows data word `dbg_mem_addr`, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_we | input | 1 | Instruction memory write strobe |
| load_addr | input | IA_W | Instruction word index to write |
| load_data | input | 32 | Instruction word to write |
| dbg_reg_addr | input | 5 | Register selected for read-back |
| dbg_reg_data | output | 32 | Value of the selected register |
| dbg_mem_addr | input | DA_W | Data word index for read-back |
| dbg_mem_data | output | 32 | Value of the selected data word |
| pc_out | output | 32 | Current program counter |

## Verification
The bench aims at the immediate sign. A core that zero-extends would turn an add of -3 into a large positive number, and would send a negative load or store offset to the wrong word. It checks branches both taken and not taken, and a backward self-branch. A core that forgets the +4 or the scaling by four would land on the wrong instruction, and the skipped writes would show up in registers. It also checks writes to register 0 and reads from it: a core that stores into register 0 would report a nonzero value and pass it on into later sums. Unsupported encodings, including an R-type word with a wrong function code, must leave every register untouched. Random runs of adds, immediates, stores and loads are compared against a bench model of the register file and memory.

// File: rtl/sc_core_pkg.sv
// Package: shared opcode values, the control bundle and immediate helper
// for the single-cycle core. Assumes fixed 32-bit instruction words.
package sc_core_pkg;
    localparam int WORD_W = 32;
    localparam int RIDX_W = 5;
    localparam int NREG   = 1 << RIDX_W;

    localparam logic [5:0] OP_SPECIAL = 6'd0;
    localparam logic [5:0] OP_JUMP    = 6'd2;
    localparam logic [5:0] OP_BEQ     = 6'd4;
    localparam logic [5:0] OP_ADDI    = 6'd8;
    localparam logic [5:0] OP_LOAD    = 6'd35;
    localparam logic [5:0] OP_STORE   = 6'd43;
    localparam logic [5:0] FN_ADD     = 6'd32;

    typedef struct packed {
        logic wr_reg;    // register write-back enabled
        logic dst_rd;    // destination is rd (else rt)
        logic use_imm;   // second operand is immediate
        logic mem_rd;    // data memory read
        logic mem_wr;    // data memory write
        logic from_mem;  // write-back source is memory
        logic is_beq;    // conditional branch
        logic is_jmp;    // absolute jump
    } ctl_t;

    function automatic logic [WORD_W-1:0] sext16(input logic [15:0] v);
        return {{(WORD_W-16){v[15]}}, v};
    endfunction
endpackage

// File: rtl/sc_core_decode.sv
// Control decoder: maps opcode/function code to the control bundle.
// Assumes any encoding not listed decodes to all-zero controls (a no-op).
module sc_core_decode
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctl_t       ctl
);
    // Purpose: one-hot style decode of the six supported operations.
    always_comb begin
        ctl = '0;
        unique case (opcode)
            OP_SPECIAL: if (funct == FN_ADD) begin
                ctl.wr_reg = 1'b1;
                ctl.dst_rd = 1'b1;
            end
            OP_ADDI: begin
                ctl.wr_reg  = 1'b1;
                ctl.use_imm = 1'b1;
            end
            OP_LOAD: begin
                ctl.wr_reg   = 1'b1;
                ctl.use_imm  = 1'b1;
                ctl.mem_rd   = 1'b1;
                ctl.from_mem = 1'b1;
            end
            OP_STORE: begin
                ctl.use_imm = 1'b1;
                ctl.mem_wr  = 1'b1;
            end
            OP_BEQ:  ctl.is_beq = 1'b1;
            OP_JUMP: ctl.is_jmp = 1'b1;
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/sc_core_regfile.sv
// Register file: two combinational read ports, one debug read port and one
// write port on the rising edge. Entry 0 is never written and reads zero.
// Assumes synchronous active-low reset clears every entry.
module sc_core_regfile
    import sc_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [RIDX_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [RIDX_W-1:0] ra_a,
    input  logic [RIDX_W-1:0] ra_b,
    input  logic [RIDX_W-1:0] ra_dbg,
    output logic [WORD_W-1:0] rd_a,
    output logic [WORD_W-1:0] rd_b,
    output logic [WORD_W-1:0] rd_dbg
);
    logic [WORD_W-1:0] regs [NREG];

    // Purpose: clear on reset, else store write-back unless it names entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    // Purpose: combinational reads with entry 0 forced to zero.
    always_comb begin
        rd_a   = (ra_a   == '0) ? '0 : regs[ra_a];
        rd_b   = (ra_b   == '0) ? '0 : regs[ra_b];
        rd_dbg = (ra_dbg == '0) ? '0 : regs[ra_dbg];
    end
endmodule

// File: rtl/sc_core_nextpc.sv
// Next-PC selection: sequential, taken branch or absolute jump.
// Assumes the branch equality flag is computed from the two register reads.
module sc_core_nextpc
    import sc_core_pkg::*;
(
    input  logic [WORD_W-1:0] pc,
    input  logic [WORD_W-1:0] imm_ext,
    input  logic [25:0]       target,
    input  logic              is_beq,
    input  logic              is_jmp,
    input  logic              ops_equal,
    output logic [WORD_W-1:0] pc_next
);
    logic [WORD_W-1:0] seq_pc;
    logic [WORD_W-1:0] br_pc;

    // Purpose: pick the successor address by priority jump, branch, sequential.
    always_comb begin
        seq_pc = pc + WORD_W'(4);
        br_pc  = seq_pc + {imm_ext[WORD_W-3:0], 2'b00};
        if (is_jmp)
            pc_next = {pc[WORD_W-1:WORD_W-4], target, 2'b00};
        else if (is_beq && ops_equal)
            pc_next = br_pc;
        else
            pc_next = seq_pc;
    end
endmodule

// File: rtl/sc_core.sv
// Single-cycle core top: PC register, instruction and data arrays, decoder,
// register file, adder and next-PC logic. Assumes one instruction retires
// per clock and that instruction memory is loaded while rst_n is held low.
module sc_core
    import sc_core_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    parameter int DMEM_DEPTH = 64,
    localparam int IA_W = $clog2(IMEM_DEPTH),
    localparam int DA_W = $clog2(DMEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_we,
    input  logic [IA_W-1:0]   load_addr,
    input  logic [31:0]       load_data,
    input  logic [4:0]        dbg_reg_addr,
    output logic [31:0]       dbg_reg_data,
    input  logic [DA_W-1:0]   dbg_mem_addr,
    output logic [31:0]       dbg_mem_data,
    output logic [31:0]       pc_out
);
    logic [WORD_W-1:0] pc_q, pc_d;
    logic [WORD_W-1:0] instr;
    logic [WORD_W-1:0] imem [IMEM_DEPTH];
    logic [WORD_W-1:0] dmem [DMEM_DEPTH];
    ctl_t              ctl;
    logic [WORD_W-1:0] rs_val, rt_val, imm_ext, opnd_b, sum, load_val, wb_val;
    logic [RIDX_W-1:0] dst;
    logic [DA_W-1:0]   dword;
    logic              dmem_we;

    // Purpose: hold the program counter, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    // Purpose: loader writes into instruction memory.
    always_ff @(posedge clk) begin
        if (load_we) imem[load_addr] <= load_data;
    end

    // Purpose: fetch the word addressed by the PC.
    assign instr = imem[pc_q[IA_W+1:2]];

    sc_core_decode u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctl    (ctl)
    );

    assign dst = ctl.dst_rd ? instr[15:11] : instr[20:16];

    sc_core_regfile u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ctl.wr_reg),
        .waddr  (dst),
        .wdata  (wb_val),
        .ra_a   (instr[25:21]),
        .ra_b   (instr[20:16]),
        .ra_dbg (dbg_reg_addr),
        .rd_a   (rs_val),
        .rd_b   (rt_val),
        .rd_dbg (dbg_reg_data)
    );

    // Purpose: operand select and the single adder used by all arithmetic.
    always_comb begin
        imm_ext = sext16(instr[15:0]);
        opnd_b  = ctl.use_imm ? imm_ext : rt_val;
        sum     = rs_val + opnd_b;
    end

    assign dword    = sum[DA_W+1:2];
    assign dmem_we  = ctl.mem_wr && rst_n;
    assign load_val = dmem[dword];
    assign wb_val   = ctl.from_mem ? load_val : sum;

    // Purpose: data memory store on the rising edge.
    always_ff @(posedge clk) begin
        if (dmem_we) dmem[dword] <= rt_val;
    end

    sc_core_nextpc u_npc (
        .pc        (pc_q),
        .imm_ext   (imm_ext),
        .target    (instr[25:0]),
        .is_beq    (ctl.is_beq),
        .is_jmp    (ctl.is_jmp),
        .ops_equal (rs_val == rt_val),
        .pc_next   (pc_d)
    );

    assign dbg_mem_data = dmem[dbg_mem_addr];
    assign pc_out       = pc_q;
endmodule

// File: rtl/sc_core_chk.sv
// Checker for sc_core: temporal properties on PC flow, stores and register 0.
// Assumes it is attached through the bind statement below.
module sc_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic        dmem_we,
    input logic [4:0]  dbg_reg_addr,
    input logic [31:0] dbg_reg_data
);
    logic [5:0] op;
    logic       known;
    assign op    = instr[31:26];
    assign known = (op == 6'd0 && instr[5:0] == 6'd32) || op == 6'd2 ||
                   op == 6'd4 || op == 6'd8 || op == 6'd35 || op == 6'd43;

    assert_reset_pc_R1: assert property (@(posedge clk) !rst_n |=> pc == 32'd0);

    assert_store_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> op == 6'd43);

    assert_beq_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'd4 && rs_val != rt_val) |=> pc == $past(pc) + 32'd4);

    assert_jump_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'd2) |=> pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00});

    assert_zero_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_reg_addr == 5'd0) |-> dbg_reg_data == 32'd0);

    assert_noop_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !known |=> pc == $past(pc) + 32'd4);

    assert_noop_nostore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !known |-> !dmem_we);
endmodule

bind sc_core sc_core_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pc           (pc_q),
    .instr        (instr),
    .rs_val       (rs_val),
    .rt_val       (rt_val),
    .dmem_we      (dmem_we),
    .dbg_reg_addr (dbg_reg_addr),
    .dbg_reg_data (dbg_reg_data)
);

// File: tb/sim_sc_core.sv
// Bench for sc_core: directed program plus seeded random straight-line runs.
module sim_sc_core;
    localparam int IA_W = 6;
    localparam int DA_W = 6;
    localparam int NI   = 1 << IA_W;
    localparam int ND   = 1 << DA_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            load_we = 1'b0;
    logic [IA_W-1:0] load_addr = '0;
    logic [31:0]     load_data = '0;
    logic [4:0]      dbg_reg_addr = '0;
    logic [31:0]     dbg_reg_data;
    logic [DA_W-1:0] dbg_mem_addr = '0;
    logic [31:0]     dbg_mem_data;
    logic [31:0]     pc_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] prog [NI];
    logic [31:0] mreg [32];
    logic [31:0] mmem [ND];
    bit          mval [ND];

    always #2 clk = ~clk;

    sc_core u0 (
        .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_addr(load_addr),
        .load_data(load_data), .dbg_reg_addr(dbg_reg_addr),
        .dbg_reg_data(dbg_reg_data), .dbg_mem_addr(dbg_mem_addr),
        .dbg_mem_data(dbg_mem_data), .pc_out(pc_out)
    );

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction
    function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(input int tgt);
        return {6'd2, 26'(tgt)};
    endfunction
    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Model of one straight-line instruction (add, addi, lw, sw, others no-op).
    task automatic model_exec(input logic [31:0] w);
        logic [4:0]  rs = w[25:21], rt = w[20:16], rd = w[15:11];
        logic [31:0] a;
        a = mreg[rs] + sx(w[15:0]);
        case (w[31:26])
            6'd0:  if (w[5:0] == 6'd32 && rd != 0) mreg[rd] = mreg[rs] + mreg[rt];
            6'd8:  if (rt != 0) mreg[rt] = a;
            6'd35: if (rt != 0) mreg[rt] = mmem[a[DA_W+1:2]];
            6'd43: begin mmem[a[DA_W+1:2]] = mreg[rt]; mval[a[DA_W+1:2]] = 1'b1; end
            default: ;
        endcase
    endtask

    // Load prog[] with reset held, then release reset and run n cycles.
    task automatic load_and_run(input int n);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < NI; i++) begin
            load_we = 1'b1; load_addr = IA_W'(i); load_data = prog[i];
            @(negedge clk);
        end
        load_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic read_reg(input int r, output logic [31:0] v);
        dbg_reg_addr = 5'(r); #0.5; v = dbg_reg_data;
    endtask
    task automatic read_mem(input int m, output logic [31:0] v);
        dbg_mem_addr = DA_W'(m); #0.5; v = dbg_mem_data;
    endtask

    initial begin
        #(4ns * 150000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < ND; i++) begin mmem[i] = '0; mval[i] = 1'b0; end

        // R1: reset state after previous activity-free start
        repeat (3) @(negedge clk);
        chk("R1 pc at reset", pc_out, 32'd0);
        read_reg(5, v); chk("R1 reg5 at reset", v, 32'd0);

        // Directed program: R2..R10
        for (int i = 0; i < NI; i++) prog[i] = enc_i(4, 0, 0, -1);
        prog[0]  = enc_i(8, 0, 1, 5);
        prog[1]  = enc_i(8, 0, 2, -3);
        prog[2]  = enc_r(1, 2, 3, 32);
        prog[3]  = enc_i(43, 0, 3, 8);
        prog[4]  = enc_i(35, 0, 4, 8);
        prog[5]  = enc_i(8, 1, 0, 7);
        prog[6]  = enc_r(0, 1, 5, 32);
        prog[7]  = enc_i(4, 1, 1, 1);
        prog[8]  = enc_i(8, 0, 6, 99);
        prog[9]  = enc_i(8, 0, 7, 1);
        prog[10] = enc_i(4, 1, 2, 1);
        prog[11] = enc_i(8, 0, 8, 2);
        prog[12] = enc_i(8, 0, 12, 40);
        prog[13] = enc_i(43, 12, 1, -4);
        prog[14] = enc_i(35, 12, 13, -4);
        prog[15] = enc_j(20);
        prog[16] = enc_i(8, 0, 9, 55);
        prog[20] = enc_i(8, 0, 10, 10);
        prog[21] = 32'hFC21_FFFF;
        prog[22] = enc_r(1, 1, 11, 34);
        prog[23] = enc_i(4, 0, 0, -1);
        load_and_run(40);

        chk("R6/R7 final pc on backward self-branch", pc_out, 32'd92);
        read_reg(1, v);  chk("R3 addi positive", v, 32'd5);
        read_reg(2, v);  chk("R3 addi sign-extended", v, 32'hFFFF_FFFD);
        read_reg(3, v);  chk("R2 register add wraps", v, 32'd2);
        read_reg(4, v);  chk("R4 load word", v, 32'd2);
        read_mem(2, v);  chk("R5 store word index 2", v, 32'd2);
        read_reg(0, v);  chk("R8 reg0 write discarded", v, 32'd0);
        read_reg(5, v);  chk("R8 reg0 reads zero in add", v, 32'd5);
        read_reg(6, v);  chk("R6 taken branch skips", v, 32'd0);
        read_reg(7, v);  chk("R6 branch target executed", v, 32'd1);
        read_reg(8, v);  chk("R6 not-taken falls through", v, 32'd2);
        read_mem(9, v);  chk("R5 store negative offset", v, 32'd5);
        read_reg(13, v); chk("R4 load negative offset", v, 32'd5);
        read_reg(9, v);  chk("R7 jump skips slot", v, 32'd0);
        read_reg(10, v); chk("R7 jump target executed", v, 32'd10);
        read_reg(11, v); chk("R9 bad funct writes nothing", v, 32'd0);
        read_reg(12, v); chk("R10 loaded program ran", v, 32'd40);
        read_reg(31, v); chk("R9 bad opcode writes nothing", v, 32'd0);
        mmem[2] = 32'd2; mmem[9] = 32'd5; mval[2] = 1'b1; mval[9] = 1'b1;

        // Random straight-line rounds: R2 R3 R4 R5 R8 R9 R11
        for (int rnd = 0; rnd < 20; rnd++) begin
            int k = 48;
            for (int i = 0; i < 32; i++) mreg[i] = '0;
            for (int i = 0; i < NI; i++) prog[i] = enc_i(4, 0, 0, -1);
            for (int i = 0; i < k; i++) begin
                int sel = $urandom_range(0, 5);
                int ra = $urandom_range(0, 31), rb = $urandom_range(0, 31);
                int rc = $urandom_range(0, 31), wi = $urandom_range(0, ND - 1);
                case (sel)
                    0, 1: prog[i] = enc_r(ra, rb, rc, 32);
                    2:    prog[i] = enc_i(8, ra, rb, int'($urandom_range(0, 65535)));
                    3:    prog[i] = enc_i(43, 0, rb, wi * 4);
                    4:    prog[i] = mval[wi] ? enc_i(35, 0, rb, wi * 4)
                                             : enc_i(8, 0, rb, wi);
                    default: prog[i] = {6'($urandom_range(44, 63)), 26'($urandom)};
                endcase
                model_exec(prog[i]);
            end
            load_and_run(k + 2);
            chk("R2/R3 random run pc", pc_out, 32'(k * 4));
            for (int r = 0; r < 32; r++) begin
                read_reg(r, v);
                chk($sformatf("R2/R3/R4/R8/R9/R11 random reg %0d", r), v, mreg[r]);
            end
            for (int m = 0; m < ND; m++) if (mval[m]) begin
                read_mem(m, v);
                chk($sformatf("R5/R11 random mem %0d", m), v, mmem[m]);
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule